// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs an 8-bit successive approximation conversion against an external comparator and DAC. Each clock it shows a trial code on `trial_o` for the DAC to turn into a reference level. It samples the comparator answer on the falling clock edge and, at the next rising edge, decides one bit of the code. Bits are decided from the most significant bit down.

A conversion frame always lasts nine clocks. Eight clocks decide the eight bits. In the ninth clock the finished code appears on `result_o`, `valid_o` goes high for that one cycle, and the active-low frame marker `sync_n_o` goes low for the same cycle. Downstream logic uses `sync_n_o` to line up with the frame.

The same edge that drives the marker low also reloads the trial register with only its top bit set. The DAC therefore has the whole marker cycle to settle before the next conversion starts deciding bits. Frames follow one another with no gap, at a nominal 1 MHz clock.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, until the first edge of frame work: `trial_o` = 8'h80, `result_o` = 0, `valid_o` = 0, `sync_n_o` = 1. The first cycle after reset release is bit-decision cycle 0.
- R2: In the first cycle of every frame (cycle 0), `trial_o` has only bit 7 set.
- R3: In frame cycle k (k = 0..7), bit 7-k is the bit under trial. That bit is set, all lower bits are 0, and higher bits hold their decided values. The bit under trial is kept when the comparator reported 1 (input at or above the trial level) and cleared otherwise. The next lower bit is then set.
- R4: With an ideal comparator that reports input >= trial, the result equals the input code. This holds for every 8-bit code, including 0x00, 0xFF, 0x7F and 0x80.
- R5: A frame lasts exactly 9 clocks. `sync_n_o` is low for one cycle, on frame cycle 8 only, and high in the eight cycles between.
- R6: `valid_o` is high exactly in the cycles where `sync_n_o` is low.
- R7: In the cycle where `sync_n_o` is low, `trial_o` is 8'h80. The trial register is reloaded by the edge that drives the marker low.
- R8: `result_o` changes only on an edge that makes `valid_o` high, and holds its value for the rest of the frame.
- R9: The comparator input is sampled only on the falling clock edge. A level that is wrong during the first half of a clock cycle but correct at the falling edge has no effect on the decided bits.
- R10: The comparator value sampled during the marker cycle is not used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge for state, falling edge for comparator capture |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparator answer: 1 when the analog input is at or above the trial level |
| trial_o | output | 8 | Trial code driven to the external DAC |
| result_o | output | 8 | Last finished conversion code |
| valid_o | output | 1 | One-cycle pulse when `result_o` is updated |
| sync_n_o | output | 1 | Active-low frame marker, low during the final cycle of each frame |

## Verification
The assertions assume that the clock runs freely and that reset is applied synchronously. They do not depend on `cmp_i` at all. Every property concerns the frame timing, the shape of the trial code and the holding of the result. This means any comparator stream, including the glitching stream the bench drives, keeps them valid. The bench changes its comparator model only one time unit after a rising edge. It changes its target value only at the falling edge of the marker cycle, where the captured answer is not used, so the ideal greater-or-equal model always matches the trial on display.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Default resolution of one conversion.
    localparam int unsigned SAR_WIDTH_DEF = 8;

    // Width of a counter that must hold values 0..width.
    function automatic int unsigned frame_ctr_w(input int unsigned width);
        return $clog2(width + 1);
    endfunction

endpackage

// File: rtl/sar_cmp_capture.sv
module sar_cmp_capture (
    input  logic clk,
    input  logic rst,
    input  logic cmp_i,
    output logic cmp_o
);

    logic cmp_q;

    // Comparator answer is taken at the falling edge, mid-cycle, after the
    // DAC has had half a period to settle on the trial code.
    always_ff @(negedge clk) begin
        if (rst) begin
            cmp_q <= 1'b0;
        end else begin
            cmp_q <= cmp_i;
        end
    end

    assign cmp_o = cmp_q;

endmodule

// File: rtl/sar_frame_ctr.sv
module sar_frame_ctr #(
    parameter int unsigned WIDTH = sar_pkg::SAR_WIDTH_DEF,
    localparam int unsigned SW   = sar_pkg::frame_ctr_w(WIDTH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] step_o,
    output logic          last_bit_o,
    output logic          sync_slot_o
);

    localparam logic [SW-1:0] LAST_BIT  = SW'(WIDTH - 1);
    localparam logic [SW-1:0] SYNC_SLOT = SW'(WIDTH);

    typedef struct packed {
        logic [SW-1:0] step;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (ctr_q.step == SYNC_SLOT) begin
            ctr_d.step = '0;
        end else begin
            ctr_d.step = ctr_q.step + SW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign step_o      = ctr_q.step;
    assign last_bit_o  = (ctr_q.step == LAST_BIT);
    assign sync_slot_o = (ctr_q.step == SYNC_SLOT);

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int unsigned WIDTH = sar_pkg::SAR_WIDTH_DEF,
    localparam int unsigned SW   = sar_pkg::frame_ctr_w(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW-1:0]    step_i,
    input  logic             cmp_i,
    input  logic             last_bit_i,
    input  logic             sync_slot_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] decided_o
);

    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] trial;
    } trial_t;

    trial_t tr_d, tr_q;

    logic [WIDTH-1:0] kept;   // trial with the bit under test resolved
    logic [WIDTH-1:0] stepped; // kept plus the next lower trial bit set

    // Bit i is under test when step == WIDTH-1-i; it becomes the new trial
    // bit when the bit above it is under test.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            kept[i] = (step_i == SW'(WIDTH - 1 - i)) ? cmp_i : tr_q.trial[i];
        end
        if (i < WIDTH - 1) begin : g_lower
            always_comb begin
                stepped[i] = (step_i == SW'(WIDTH - 2 - i)) ? 1'b1 : kept[i];
            end
        end else begin : g_top
            always_comb begin
                stepped[i] = kept[i];
            end
        end
    end

    always_comb begin
        tr_d = tr_q;
        if (sync_slot_i) begin
            tr_d.trial = tr_q.trial;
        end else if (last_bit_i) begin
            tr_d.trial = MSB_ONLY;
        end else begin
            tr_d.trial = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tr_q.trial <= MSB_ONLY;
        end else begin
            tr_q <= tr_d;
        end
    end

    assign trial_o   = tr_q.trial;
    assign decided_o = kept;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int unsigned WIDTH = sar_pkg::SAR_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] result_o,
    output logic             valid_o,
    output logic             sync_n_o
);

    localparam int unsigned SW = sar_pkg::frame_ctr_w(WIDTH);

    logic [SW-1:0]    step;
    logic             last_bit;
    logic             sync_slot;
    logic             cmp_s;
    logic [WIDTH-1:0] decided;

    sar_cmp_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .cmp_i (cmp_i),
        .cmp_o (cmp_s)
    );

    sar_frame_ctr #(.WIDTH(WIDTH)) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .step_o      (step),
        .last_bit_o  (last_bit),
        .sync_slot_o (sync_slot)
    );

    sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
        .clk         (clk),
        .rst         (rst),
        .step_i      (step),
        .cmp_i       (cmp_s),
        .last_bit_i  (last_bit),
        .sync_slot_i (sync_slot),
        .trial_o     (trial_o),
        .decided_o   (decided)
    );

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             valid;
        logic             sync_n;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d        = out_q;
        out_d.valid  = 1'b0;
        out_d.sync_n = 1'b1;
        if (last_bit) begin
            out_d.result = decided;
            out_d.valid  = 1'b1;
            out_d.sync_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.result <= '0;
            out_q.valid  <= 1'b0;
            out_q.sync_n <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.result;
    assign valid_o  = out_q.valid;
    assign sync_n_o = out_q.sync_n;

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] trial_o,
    input logic [WIDTH-1:0] result_o,
    input logic             valid_o,
    input logic             sync_n_o
);

    localparam int unsigned SW = $clog2(WIDTH + 1);

    // Cycles since reset or since the last marker cycle.
    logic [SW-1:0]    cnt_q;
    logic [WIDTH-1:0] low_mask;
    logic [WIDTH-1:0] trial_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!sync_n_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + SW'(1);
        end
    end

    always_comb begin
        low_mask  = '0;
        trial_bit = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (int'(cnt_q) < WIDTH && i <= WIDTH - 1 - int'(cnt_q)) begin
                low_mask[i] = 1'b1;
            end
            if (int'(cnt_q) < WIDTH && i == WIDTH - 1 - int'(cnt_q)) begin
                trial_bit[i] = 1'b1;
            end
        end
    end

    a_r5_sync_on_slot: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == SW'(WIDTH)) |-> !sync_n_o);
    a_r5_sync_only_on_slot: assert property (@(posedge clk) disable iff (rst)
        !sync_n_o |-> (cnt_q == SW'(WIDTH)));
    a_r5_sync_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !sync_n_o |=> sync_n_o);
    a_r6_valid_with_sync: assert property (@(posedge clk) disable iff (rst)
        valid_o == !sync_n_o);
    a_r7_reload_msb: assert property (@(posedge clk) disable iff (rst)
        !sync_n_o |-> (trial_o == {1'b1, {(WIDTH-1){1'b0}}}));
    a_r3_trial_shape: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt_q) < WIDTH) |-> ((trial_o & low_mask) == trial_bit));
    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(result_o));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trial_o  (trial_o),
    .result_o (result_o),
    .valid_o  (valid_o),
    .sync_n_o (sync_n_o)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmp = 1'b0;
    logic [W-1:0] trial, result;
    logic         valid, sync_n;

    logic [W-1:0] target = '0;
    logic         glitch_en = 1'b0;
    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;

    sar_adc_ctrl #(.WIDTH(W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .cmp_i    (cmp),
        .trial_o  (trial),
        .result_o (result),
        .valid_o  (valid),
        .sync_n_o (sync_n)
    );

    always #5 clk = ~clk;

    // Ideal comparator; in glitch mode it first shows the wrong answer and
    // settles to the right one well before the falling edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (glitch_en) begin
                cmp = !(target >= trial);
                #2;
            end
            cmp = (target >= trial);
        end
    end

    function automatic logic [W-1:0] exp_trial(input logic [W-1:0] t, input int k);
        logic [W-1:0] hi;
        int b;
        b  = W - 1 - k;
        hi = '1;
        hi = hi << (b + 1);
        return (t & hi) | (W'(1) << b);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Called just after the falling edge before frame cycle 0.
    task automatic run_conv(input logic [W-1:0] tgt, input logic glitch);
        logic [W-1:0] prev;
        prev      = result;
        target    = tgt;
        glitch_en = glitch;
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            if (k == 0) check("R2 msb-only first trial", trial, 8'h80);
            check("R3 trial per cycle", trial, exp_trial(tgt, k));
            check("R5 sync high mid-frame", W'(sync_n), W'(1));
            check("R6 valid low mid-frame", W'(valid), W'(0));
            check("R8 result held", result, prev);
        end
        @(negedge clk);
        check("R5 sync low on cycle 8", W'(sync_n), W'(0));
        check("R6 valid with sync", W'(valid), W'(1));
        check("R7 trial reload", trial, 8'h80);
        if (glitch) check("R9 first-half glitch ignored", result, tgt);
        else        check("R4 result equals input", result, tgt);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        target = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset trial", trial, 8'h80);
        check("R1 reset result", result, 8'h00);
        check("R1 reset valid", W'(valid), W'(0));
        check("R1 reset sync", W'(sync_n), W'(1));
        @(posedge clk);
        #1 rst = 1'b0;
        run_conv(8'h00, 1'b0);
        run_conv(8'hFF, 1'b0);
        run_conv(8'h80, 1'b0);
        run_conv(8'h7F, 1'b0);
        run_conv(8'h01, 1'b0);
        run_conv(8'hFE, 1'b0);
        run_conv(8'h55, 1'b1);
        run_conv(8'hAA, 1'b1);
        run_conv(8'h00, 1'b1);
        run_conv(8'hFF, 1'b1);
        // R10: target swaps during the marker cycle; the stale answer is unused.
        run_conv(8'h3C, 1'b0);
        for (int n = 0; n < 40; n++) begin
            run_conv(W'($urandom_range(0, 255)), ($urandom_range(0, 3) == 0));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule